// File: doc/BRIEF.md
# Stack Machine Arithmetic Execute Unit

This block is the arithmetic and logic execute stage of a 32-bit zero-operand stack processor. Each cycle it may accept one 4-bit opcode together with a valid strobe and a literal word. It keeps the data stack in an internal register file. It either pushes the literal or combines the two topmost entries into one result. A single cycle later it reports the new top of stack, the new depth and any error.

The unit handles five operations: literal push, wrapping addition, XOR, AND and one shift opcode. The shift opcode picks its direction from the size of the shift operand. Amounts below the word width shift right. Larger amounts shift left by the excess over the word width. Operations that cannot complete are refused, the stack is left untouched, and one error flag is raised for that operation. An opcode outside the supported set is also refused and flagged.

Top module: `stack_alu_exec`

## Requirements
- R1: Opcode 0 pushes `lit_word`. The depth rises by one and `top_word` becomes the literal.
- R2: Opcode 1 pops the top entry b and the entry a beneath it, and pushes a + b modulo 2^32. The depth drops by one.
- R3: Opcode 2 with b below 32 pushes a logically shifted right by b, with zeros filling from the top.
- R4: Opcode 2 with b of 32 or more pushes a shifted left by b − 32. The result is zero when b − 32 is 32 or more.
- R5: Opcode 3 pops a and b and pushes a XOR b.
- R6: Opcode 4 pops a and b and pushes a AND b.
- R7: An opcode from 1 to 4 issued with fewer than two entries raises `err_underflow`. Depth and top stay unchanged.
- R8: Opcode 0 issued with the stack holding DEPTH entries (16 by default) raises `err_overflow`. Depth and top stay unchanged.
- R9: Opcodes 5 to 15 raise `err_unsupported`. Depth and top stay unchanged.
- R10: `res_valid` is high exactly in the cycle after each accepted `op_valid`. `top_word` and `depth` show the outcome in that cycle. At most one error flag is high, and only while `res_valid` is high.
- R11: After reset the depth is 0, `top_word` is 0 and all flags are low. `top_word` reads 0 whenever the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe, one operation per high cycle |
| op_code | input | 4 | Operation code |
| lit_word | input | 32 | Literal for the push opcode |
| res_valid | output | 1 | Outcome of the previous operation is shown |
| top_word | output | 32 | Current top of stack, 0 when empty |
| depth | output | 5 | Number of stack entries |
| err_underflow | output | 1 | Previous operation lacked operands |
| err_overflow | output | 1 | Previous push found the stack full |
| err_unsupported | output | 1 | Previous opcode is not handled here |

## Verification
The assertions assume that `op_code` and `lit_word` are defined whenever `op_valid` is high. They also assume that `op_valid` stays low during reset, since their `$past` terms refer to values sampled before the clock edge. The bench drives all inputs on the falling edge and holds the strobe for exactly one cycle per operation, which keeps the stimulus within these assumptions. It also keeps a reference stack of its own, so it reaches the full and empty depths on purpose rather than by chance.

// File: rtl/stack_alu_exec.sv
module stack_alu_exec #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [3:0]                   op_code,
  input  logic [DW-1:0]                lit_word,
  output logic                         res_valid,
  output logic [DW-1:0]                top_word,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         err_underflow,
  output logic                         err_overflow,
  output logic                         err_unsupported
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [DW-1:0] WIDTH_V = DW[DW-1:0];
  localparam logic [3:0] OP_LIT = 4'd0, OP_ADD = 4'd1, OP_SHF = 4'd2,
                         OP_XOR = 4'd3, OP_AND = 4'd4;

  logic [DW-1:0] stk [DEPTH];
  logic [CW-1:0] dm1, dm2;
  logic [DW-1:0] opa, opb, left_amt, result;
  logic          is_bin;

  assign dm1      = depth - 1'b1;
  assign dm2      = depth - 2'd2;
  assign opb      = stk[dm1[IW-1:0]];
  assign opa      = stk[dm2[IW-1:0]];
  assign top_word = (depth == '0) ? '0 : opb;
  assign is_bin   = (op_code >= OP_ADD) && (op_code <= OP_AND);
  assign left_amt = opb - WIDTH_V;

  always_comb begin
    unique case (op_code)
      OP_ADD:  result = opa + opb;
      OP_SHF:  if (opb < WIDTH_V)          result = opa >> opb;
               else if (left_amt < WIDTH_V) result = opa << left_amt;
               else                         result = '0;
      OP_XOR:  result = opa ^ opb;
      OP_AND:  result = opa & opb;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth           <= '0;
      res_valid       <= 1'b0;
      err_underflow   <= 1'b0;
      err_overflow    <= 1'b0;
      err_unsupported <= 1'b0;
    end else begin
      res_valid       <= op_valid;
      err_underflow   <= 1'b0;
      err_overflow    <= 1'b0;
      err_unsupported <= 1'b0;
      if (op_valid) begin
        if (op_code == OP_LIT) begin
          if (depth == FULL) err_overflow <= 1'b1;
          else begin
            stk[depth[IW-1:0]] <= lit_word;
            depth <= depth + 1'b1;
          end
        end else if (is_bin) begin
          if (depth < CW'(2)) err_underflow <= 1'b1;
          else begin
            stk[dm2[IW-1:0]] <= result;
            depth <= dm1;
          end
        end else begin
          err_unsupported <= 1'b1;
        end
      end
    end
  end

  a_r1_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_LIT && depth < FULL
    |=> top_word == $past(lit_word) && depth == $past(depth) + 1'b1);

  a_r2_binary_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_bin && depth >= CW'(2) |=> depth == $past(depth) - 1'b1 && !err_underflow);

  a_r7_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_bin && depth < CW'(2) |=> err_underflow && $stable(depth) && $stable(top_word));

  a_r8_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_LIT && depth == FULL |=> err_overflow && $stable(depth) && $stable(top_word));

  a_r9_unsupported_holds: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code > OP_AND |=> err_unsupported && $stable(depth) && $stable(top_word));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_underflow, err_overflow, err_unsupported})
    && ((err_underflow || err_overflow || err_unsupported) -> res_valid));

  a_r11_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL && (depth == '0 -> top_word == '0));
endmodule

// File: tb/test_stack_alu_exec.sv
module test_stack_alu_exec;
  logic        clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] lit_word = '0;
  logic        res_valid, err_underflow, err_overflow, err_unsupported;
  logic [31:0] top_word;
  logic [4:0]  depth;

  stack_alu_exec i_stack_alu_exec (.clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .op_code(op_code), .lit_word(lit_word), .res_valid(res_valid), .top_word(top_word),
    .depth(depth), .err_underflow(err_underflow), .err_overflow(err_overflow),
    .err_unsupported(err_unsupported));

  always #10 clk = ~clk;

  typedef struct { logic [31:0] top; int dep; bit uf, ov, un; string req; } exp_t;
  exp_t        sbq[$];
  logic [31:0] mstk[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] lit, input string req);
    exp_t e;
    logic [31:0] a, b, r, amt;
    e.uf = 0; e.ov = 0; e.un = 0; e.req = req;
    if (op == 4'd0) begin
      if (mstk.size() == 16) e.ov = 1; else mstk.push_back(lit);
    end else if (op <= 4'd4) begin
      if (mstk.size() < 2) e.uf = 1;
      else begin
        b = mstk.pop_back(); a = mstk.pop_back();
        amt = b - 32'd32;
        case (op)
          4'd1: r = a + b;
          4'd2: r = (b < 32) ? (a >> b) : ((amt >= 32) ? 32'd0 : (a << amt));
          4'd3: r = a ^ b;
          default: r = a & b;
        endcase
        mstk.push_back(r);
      end
    end else e.un = 1;
    e.dep = mstk.size();
    e.top = (mstk.size() == 0) ? 32'd0 : mstk[$];
    sbq.push_back(e);
    op_valid = 1'b1; op_code = op; lit_word = lit;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sbq.size() == 0) chk(0, "R10", "unexpected res_valid", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(top_word == e.top, e.req, "top_word", top_word, e.top);
        chk(depth == 5'(e.dep), e.req, "depth", 32'(depth), 32'(e.dep));
        chk({err_underflow, err_overflow, err_unsupported} == {e.uf, e.ov, e.un}, e.req, "flags",
            {29'd0, err_underflow, err_overflow, err_unsupported}, {29'd0, e.uf, e.ov, e.un});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", sbq.size());
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(depth == 0 && top_word == 0, "R11", "reset depth/top", top_word, 0);
    chk(!res_valid && !err_underflow && !err_overflow && !err_unsupported, "R11", "reset flags",
        {28'd0, res_valid, err_underflow, err_overflow, err_unsupported}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(4'd1, 0, "R7");
    issue(4'd0, 32'h11, "R1");
    issue(4'd2, 0, "R7");
    issue(4'd0, 7, "R1");
    issue(4'd1, 0, "R2");
    issue(4'd0, 32'hFFFF_FFFF, "R1");
    issue(4'd0, 2, "R1");
    issue(4'd1, 0, "R2");
    issue(4'd0, 32'h8000_0000, "R1"); issue(4'd0, 4, "R1");  issue(4'd2, 0, "R3");
    issue(4'd0, 32'hF000_0001, "R1"); issue(4'd0, 0, "R1");  issue(4'd2, 0, "R3");
    issue(4'd0, 31, "R1");            issue(4'd2, 0, "R3");
    issue(4'd0, 1, "R1");  issue(4'd0, 35, "R1");            issue(4'd2, 0, "R4");
    issue(4'd0, 1, "R1");  issue(4'd0, 32, "R1");            issue(4'd2, 0, "R4");
    issue(4'd0, 1, "R1");  issue(4'd0, 63, "R1");            issue(4'd2, 0, "R4");
    issue(4'd0, 5, "R1");  issue(4'd0, 64, "R1");            issue(4'd2, 0, "R4");
    issue(4'd0, 5, "R1");  issue(4'd0, 32'hFFFF_FFFF, "R1"); issue(4'd2, 0, "R4");
    issue(4'd0, 32'hA5A5_0F0F, "R1"); issue(4'd0, 32'h0FF0_FFFF, "R1"); issue(4'd3, 0, "R5");
    issue(4'd0, 32'h1234_5678, "R1"); issue(4'd4, 0, "R6");
    for (int k = 5; k < 16; k++) issue(4'(k), 32'hDEAD_0000 + k, "R9");
    while (mstk.size() < 16) issue(4'd0, 32'h100 + mstk.size(), "R1");
    issue(4'd0, 32'hBAD0_BAD0, "R8");
    issue(4'd9, 0, "R9");
    issue(4'd4, 0, "R6");
    while (mstk.size() > 1) issue(4'd1, 0, "R2");
    issue(4'd3, 0, "R7");
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R10", "results outstanding", sbq.size(), 0);
    chk(!res_valid, "R10", "res_valid idle", {31'd0, res_valid}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule